// File: doc/BRIEF.md
# Banked Memory Paging Unit

This block widens the 16-bit memory address of an 8-bit CPU into a larger physical space holding up to 512 KB of ROM, an 8 KB on-board user RAM and an optional battery-backed cartridge RAM of two 16 KB pages. The CPU space is cut into four 16 KB quarters. The lower three are ROM windows, each steered to any 16 KB ROM bank by its own bank register. The top quarter is the user RAM, seen twice.

The four control registers live in the last four bytes of CPU memory space. A memory write to one of them loads the register, and the write also reaches the user RAM byte at the mirrored location. Only memory-request cycles are translated. Cycles made for I/O ports leave the unit idle. The output is a physical offset together with a region code. The register update is clocked, and the translation from CPU address to physical address is purely combinational.

Top module: `mem_pager`

## Requirements
- R1: While `mem_req` is low, `region` is 0 (none) and `phys_addr` is 0, whatever the address.
- R2: For a memory request to CPU addresses 0x0000–0xBFFF, window w = `cpu_addr[15:14]` (0, 1 or 2) gives `region` = 1 (ROM) and `phys_addr` = bank[w] * 0x4000 + `cpu_addr[13:0]`.
- R3: For a memory request to 0xC000–0xFFFF, `region` = 3 (user RAM) and `phys_addr` = `cpu_addr[12:0]`, so 0xC000 and 0xE000 reach the same byte.
- R4: A memory write to 0xFFFD, 0xFFFE or 0xFFFF loads the low 5 data bits into the bank register of window 0, 1 or 2. Higher data bits are ignored. The new bank applies from the cycle after the write.
- R5: A memory write to 0xFFFC loads the RAM select register. Data bit 3 enables cartridge RAM and data bit 2 picks its page. The new setting applies from the cycle after the write.
- R6: While cartridge RAM is enabled, a request to 0x8000–0xBFFF gives `region` = 2 (cartridge RAM) and `phys_addr` = page * 0x4000 + `cpu_addr[13:0]`. Windows 0 and 1 still map to ROM.
- R7: A write strobe without `mem_req` (an I/O cycle) changes no register.
- R8: After reset the window banks are 0, 1 and 2, and cartridge RAM is disabled, so CPU 0x0000–0xBFFF reads ROM linearly.
- R9: A memory write to 0xFFFC–0xFFFF is itself presented as a user RAM access at offset 0x1FFC–0x1FFF in the same cycle.
- R10: Reads of 0xFFFC–0xFFFF, and writes to their mirrors such as 0xDFFC–0xDFFF, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory-request strobe from the CPU |
| wr | input | 1 | Write strobe (high for a write cycle) |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| phys_addr | output | 19 | Physical offset within the selected region |
| region | output | 2 | Region code: 0 none, 1 ROM, 2 cartridge RAM, 3 user RAM |

## Verification
The physical address and region are combinational, so they are due in the same cycle as the address. The bench samples them one time step after it drives the inputs on a falling edge. A register write is captured on the rising edge inside the write cycle, and its effect is therefore due on the next cycle. The bench checks the effect only after that edge, and it checks the mirrored RAM access during the write cycle itself, before the edge. Bank values, page selections and offsets are swept, and the expected values are computed arithmetically from a shadow copy of the registers.

// File: rtl/pager_pkg.sv
package pager_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_ROM  = 2'd1,
      RGN_CRAM = 2'd2,
      RGN_URAM = 2'd3
   } rgn_e;

   localparam int CPU_AW   = 16;
   localparam int FRAME_AW = CPU_AW - 2;
   localparam int NFRAMES  = 3;

endpackage

// File: rtl/pager_decode.sv
module pager_decode
   import pager_pkg::*;
(
   input  logic              mem_req,
   input  logic              wr,
   input  logic [CPU_AW-1:0] cpu_addr,
   output logic              reg_we,
   output logic [1:0]        reg_sel
);

   // control window: top four bytes of CPU space
   logic in_window;

   always_comb begin
      in_window = &cpu_addr[CPU_AW-1:2];
      reg_we    = mem_req & wr & in_window;
      reg_sel   = cpu_addr[1:0];
   end

endmodule

// File: rtl/pager_regs.sv
module pager_regs
   import pager_pkg::*;
#(
   parameter int BANK_W  = 5,
   parameter int EN_BIT  = 3,
   parameter int PG_BIT  = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             reg_we,
   input  logic [1:0]                       reg_sel,
   input  logic [7:0]                       wdata,
   output logic [NFRAMES-1:0][BANK_W-1:0]   banks,
   output logic                             cram_en,
   output logic                             cram_page
);

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   // one bank register per ROM window, selected by low address bits 1..3
   for (genvar f = 0; f < NFRAMES; f++) begin : g_bank
      localparam logic [1:0]        SEL_CODE = 2'(f + 1);
      localparam logic [BANK_W-1:0] RST_BANK = BANK_W'(f);
      always_ff @(posedge clk) begin
         if (!rst_n)
            banks[f] <= RST_BANK;
         else if (reg_we && reg_sel == SEL_CODE)
            banks[f] <= wdata[BANK_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cram_en   <= 1'b0;
         cram_page <= 1'b0;
      end else if (reg_we && reg_sel == 2'd0) begin
         cram_en   <= wdata[EN_BIT];
         cram_page <= wdata[PG_BIT];
      end
   end

endmodule

// File: rtl/pager_xlate.sv
module pager_xlate
   import pager_pkg::*;
#(
   parameter int BANK_W   = 5,
   parameter int URAM_AW  = 13,
   parameter bit HAS_CRAM = 1'b1,
   localparam int PA_W    = BANK_W + FRAME_AW
) (
   input  logic                           mem_req,
   input  logic [CPU_AW-1:0]              cpu_addr,
   input  logic [NFRAMES-1:0][BANK_W-1:0] banks,
   input  logic                           cram_en,
   input  logic                           cram_page,
   output logic [PA_W-1:0]                phys_addr,
   output rgn_e                           region
);

   logic [FRAME_AW-1:0] off;
   logic [1:0]          quarter;
   logic                cram_on;

   assign off     = cpu_addr[FRAME_AW-1:0];
   assign quarter = cpu_addr[CPU_AW-1:FRAME_AW];

   // variant: cartridge RAM fitted or not
   if (HAS_CRAM) begin : g_cram
      assign cram_on = cram_en;
   end else begin : g_nocram
      logic unused_cram;
      assign unused_cram = cram_en;
      assign cram_on     = 1'b0;
   end

   always_comb begin
      phys_addr = '0;
      region    = RGN_NONE;
      if (mem_req) begin
         unique case (quarter)
            2'd0: begin
               region    = RGN_ROM;
               phys_addr = {banks[0], off};
            end
            2'd1: begin
               region    = RGN_ROM;
               phys_addr = {banks[1], off};
            end
            2'd2: begin
               if (cram_on) begin
                  region    = RGN_CRAM;
                  phys_addr = {{(PA_W-FRAME_AW-1){1'b0}}, cram_page, off};
               end else begin
                  region    = RGN_ROM;
                  phys_addr = {banks[2], off};
               end
            end
            default: begin
               region    = RGN_URAM;
               phys_addr = {{(PA_W-URAM_AW){1'b0}}, cpu_addr[URAM_AW-1:0]};
            end
         endcase
      end
   end

endmodule

// File: rtl/mem_pager.sv
module mem_pager
   import pager_pkg::*;
#(
   parameter int BANK_W   = 5,
   parameter int URAM_AW  = 13,
   parameter bit HAS_CRAM = 1'b1,
   parameter int EN_BIT   = 3,
   parameter int PG_BIT   = 2,
   localparam int PA_W    = BANK_W + FRAME_AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mem_req,
   input  logic            wr,
   input  logic [15:0]     cpu_addr,
   input  logic [7:0]      cpu_wdata,
   output logic [PA_W-1:0] phys_addr,
   output logic [1:0]      region
);

   if (BANK_W < 2 || BANK_W > 8) begin : g_bad_bank
      $error("mem_pager: BANK_W must lie in 2..8");
   end
   if (URAM_AW < 1 || URAM_AW > FRAME_AW) begin : g_bad_uram
      $error("mem_pager: URAM_AW must lie in 1..FRAME_AW");
   end
   if (EN_BIT > 7 || PG_BIT > 7 || EN_BIT == PG_BIT) begin : g_bad_bits
      $error("mem_pager: select register bits must be distinct and within a byte");
   end

   logic                           reg_we;
   logic [1:0]                     reg_sel;
   logic [NFRAMES-1:0][BANK_W-1:0] banks;
   logic                           cram_en;
   logic                           cram_page;
   rgn_e                           rgn;

   pager_decode u_dec (
      .mem_req  (mem_req),
      .wr       (wr),
      .cpu_addr (cpu_addr),
      .reg_we   (reg_we),
      .reg_sel  (reg_sel)
   );

   pager_regs #(
      .BANK_W (BANK_W),
      .EN_BIT (EN_BIT),
      .PG_BIT (PG_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .wdata     (cpu_wdata),
      .banks     (banks),
      .cram_en   (cram_en),
      .cram_page (cram_page)
   );

   pager_xlate #(
      .BANK_W   (BANK_W),
      .URAM_AW  (URAM_AW),
      .HAS_CRAM (HAS_CRAM)
   ) u_xlate (
      .mem_req   (mem_req),
      .cpu_addr  (cpu_addr),
      .banks     (banks),
      .cram_en   (cram_en),
      .cram_page (cram_page),
      .phys_addr (phys_addr),
      .region    (rgn)
   );

   assign region = rgn;

endmodule

// File: rtl/pager_chk.sv
module pager_chk #(
   parameter int BANK_W = 5,
   parameter int PA_W   = 19
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  mem_req,
   input logic                  wr,
   input logic [15:0]           cpu_addr,
   input logic [7:0]            cpu_wdata,
   input logic [PA_W-1:0]       phys_addr,
   input logic [1:0]            region,
   input logic [3*BANK_W-1:0]   bank_vec,
   input logic                  cram_en
);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (region == 2'd0 && phys_addr == '0));

   // R3
   uram_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cpu_addr[15:14] == 2'b11) |-> (region == 2'd3 && phys_addr[12:0] == cpu_addr[12:0]));

   // R2
   rom_win0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cpu_addr[15:14] == 2'b00) |->
         (region == 2'd1 && phys_addr == {bank_vec[BANK_W-1:0], cpu_addr[13:0]}));

   // R4
   bank2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && wr && cpu_addr == 16'hFFFF) |=>
         (bank_vec[3*BANK_W-1:2*BANK_W] == $past(cpu_wdata[BANK_W-1:0])));

   // R7
   io_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |=> ($stable(bank_vec) && $stable(cram_en)));

   // R6
   cram_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cpu_addr[15:14] == 2'b10) |-> (region == (cram_en ? 2'd2 : 2'd1)));

endmodule

bind mem_pager pager_chk #(.BANK_W(BANK_W), .PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .wr        (wr),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .phys_addr (phys_addr),
   .region    (region),
   .bank_vec  (banks),
   .cram_en   (cram_en)
);

// File: tb/tb_mem_pager.sv
module tb_mem_pager;

   localparam int PA_W = 19;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            mem_req = 1'b0;
   logic            wr = 1'b0;
   logic [15:0]     cpu_addr = '0;
   logic [7:0]      cpu_wdata = '0;
   logic [PA_W-1:0] phys_addr;
   logic [1:0]      region;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int sh_bank [3];
   bit sh_en;
   bit sh_page;

   always #4 clk = ~clk;

   mem_pager dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .wr        (wr),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .phys_addr (phys_addr),
      .region    (region)
   );

   task automatic expect_eq(input string req, input int act_r, input int exp_r,
                            input int act_a, input int exp_a);
      total++;
      if (act_r != exp_r || act_a != exp_a) begin
         bad++;
         $display("FAIL %s: region=%0d addr=%h, expected region=%0d addr=%h",
                  req, act_r, act_a, exp_r, exp_a);
      end
   endtask

   // expected translation from the shadow registers
   task automatic model(input logic [15:0] a, output int r, output int pa);
      int q;
      q = int'(a[15:14]);
      if (q == 3) begin
         r = 3; pa = int'(a[12:0]);
      end else if (q == 2 && sh_en) begin
         r = 2; pa = int'(sh_page) * 16384 + int'(a[13:0]);
      end else begin
         r = 1; pa = sh_bank[q] * 16384 + int'(a[13:0]);
      end
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a);
      int r, pa;
      @(negedge clk);
      mem_req = 1'b1; wr = 1'b0; cpu_addr = a;
      #1;
      model(a, r, pa);
      expect_eq(req, int'(region), r, int'(phys_addr), pa);
   endtask

   // memory write; the mirrored RAM access is checked inside the write cycle
   task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      mem_req = 1'b1; wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      #1;
      if (a >= 16'hFFFC)
         expect_eq("R9", int'(region), 3, int'(phys_addr), int'(a[12:0]));
      @(negedge clk);
      mem_req = 1'b0; wr = 1'b0;
      if (a == 16'hFFFC) begin
         sh_en = d[3]; sh_page = d[2];
      end else if (a >= 16'hFFFD) begin
         sh_bank[int'(a) - 16'hFFFD] = int'(d[4:0]);
      end
   endtask

   task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      mem_req = 1'b0; wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      #1;
      expect_eq("R1", int'(region), 0, int'(phys_addr), 0);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic sweep_all(input string req);
      for (int q = 0; q < 4; q++) begin
         rd_chk(req, 16'(q * 16384));
         rd_chk(req, 16'(q * 16384 + 16383));
         rd_chk(req, 16'(q * 16384 + 5461));
      end
   endtask

   initial begin
      sh_bank[0] = 0; sh_bank[1] = 1; sh_bank[2] = 2;
      sh_en = 1'b0; sh_page = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset state, linear ROM view
      sweep_all("R8");
      rd_chk("R8", 16'h8000);

      // R1: no request, no region
      @(negedge clk);
      mem_req = 1'b0; cpu_addr = 16'h1234;
      #1;
      expect_eq("R1", int'(region), 0, int'(phys_addr), 0);

      // R3: user RAM mirror
      rd_chk("R3", 16'hC000);
      rd_chk("R3", 16'hE000);
      rd_chk("R3", 16'hDFFF);
      rd_chk("R3", 16'hFFFB);

      // R2/R4: every bank value through every window, upper data bits set
      for (int f = 0; f < 3; f++) begin
         for (int b = 0; b < 32; b++) begin
            mem_wr(16'(16'hFFFD + f), 8'(b) | 8'hE0);
            rd_chk("R4", 16'(f * 16384));
            rd_chk("R2", 16'(f * 16384 + 16383));
            rd_chk("R2", 16'(f * 16384 + (b * 509) % 16384));
         end
      end
      sweep_all("R2");

      // R7: I/O-cycle writes to the register addresses
      io_wr(16'hFFFD, 8'h11);
      io_wr(16'hFFFC, 8'h08);
      sweep_all("R7");

      // R10: reads of the window and writes to its mirrors
      rd_chk("R10", 16'hFFFC);
      rd_chk("R10", 16'hFFFF);
      mem_wr(16'hDFFC, 8'h0C);
      mem_wr(16'hDFFE, 8'h05);
      mem_wr(16'hEFFF, 8'h07);
      sweep_all("R10");

      // R5/R6: cartridge RAM pages
      for (int s = 0; s < 4; s++) begin
         mem_wr(16'hFFFC, 8'(s << 2) | 8'hF3);
         rd_chk("R5", 16'h8000);
         rd_chk("R6", 16'hBFFF);
         rd_chk("R6", 16'h9ABC);
         rd_chk("R6", 16'h0123);
         rd_chk("R6", 16'h4567);
      end
      mem_wr(16'hFFFC, 8'h00);
      rd_chk("R5", 16'h8001);

      // R4: bank change takes effect the cycle after the write, not before
      mem_wr(16'hFFFE, 8'h1A);
      rd_chk("R4", 16'h4000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: expected completion, got timeout");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule